// File: doc/BRIEF.md
# Decimal adjust arithmetic unit

This block applies decimal correction to an 8-bit accumulator byte and the byte that sits above it. A 3-bit operation code selects one of six corrections. Two fix up packed decimal after an add or a subtract. Two fix up unpacked decimal after an add or a subtract. One splits a byte into a quotient and a remainder by a base. One folds a two-digit value in that base back into a single byte.

The unit is purely combinational. It takes the carry and auxiliary-carry flags that came out of the preceding arithmetic operation. It returns the corrected bytes, new carry and auxiliary-carry flags, and zero, sign and parity flags for the resulting low byte. Its results are meant to be written back into the accumulator and the flag register in the same cycle.

Top module: `dec_adjust_unit`

## Requirements
- R1: With op 0 (packed add adjust), the low byte gets 6 added and af_o is set when its low nibble exceeds 9 or af_i is 1; otherwise af_o is 0. hi_o equals hi_i for op 0 and op 1.
- R2: With op 0, 0x60 is then added and cf_o is set when the original low byte exceeds 0x99 or cf_i is 1; otherwise cf_o is 0. The test is made on the original byte, not the partly corrected one.
- R3: With op 1 (packed subtract adjust), under the nibble condition of R1, 6 is subtracted and af_o is set; in that case cf_o is also set when the original byte is below 6.
- R4: With op 1, 0x60 is then subtracted and cf_o is set when the original byte exceeds 0x99 or cf_i is 1.
- R5: For every op, zf_o is 1 when lo_o is zero, sf_o equals lo_o bit 7, and pf_o is 1 when lo_o holds an even number of ones.
- R6: With op 2 (unpacked add adjust), when the nibble condition holds, lo_o = (lo_i+6) & 0x0F. hi_o = hi_i+1, plus 1 more when lo_i exceeds 0xF9, modulo 256. cf_o and af_o are both set.
- R7: With op 3 (unpacked subtract adjust), when the nibble condition holds, lo_o = (lo_i-6) & 0x0F. hi_o = hi_i-1, minus 1 more when lo_i is below 6, modulo 256. cf_o and af_o are both set.
- R8: With op 2 or op 3 and the nibble condition false, lo_o = lo_i & 0x0F, hi_o = hi_i, and cf_o and af_o are 0.
- R9: With op 4 (split), hi_o = lo_i / base_i and lo_o = lo_i mod base_i. A zero base gives hi_o = 0xFF and lo_o = lo_i.
- R10: With op 5 (combine), lo_o = (hi_i*base_i + lo_i) mod 256 and hi_o = 0.
- R11: With op 4 or op 5, cf_o equals cf_i and af_o equals af_i.
- R12: Op codes 6 and 7 change nothing: lo_o = lo_i, hi_o = hi_i, cf_o = cf_i, af_o = af_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 3 | Operation code: 0 packed add, 1 packed sub, 2 unpacked add, 3 unpacked sub, 4 split, 5 combine |
| lo_i | input | 8 | Accumulator low byte |
| hi_i | input | 8 | Companion high byte |
| base_i | input | 8 | Base for split and combine |
| cf_i | input | 1 | Incoming carry flag |
| af_i | input | 1 | Incoming auxiliary-carry flag |
| lo_o | output | 8 | Corrected low byte |
| hi_o | output | 8 | Corrected high byte |
| cf_o | output | 1 | Resulting carry flag |
| af_o | output | 1 | Resulting auxiliary-carry flag |
| zf_o | output | 1 | Zero flag of lo_o |
| sf_o | output | 1 | Sign flag of lo_o |
| pf_o | output | 1 | Even parity flag of lo_o |

## Verification
The unit holds no state, so a wrong correction term, a mis-chosen threshold or a bad divider step shows at the ports in the same cycle the operands are applied. Nothing is deferred to a later cycle. The faults most likely to hide are a carry judged on the intermediate byte, and the extra high-byte step at the 0xF9 and 0x06 edges. Both appear only for a narrow band of low-byte values, so every op code is swept across all 256 low-byte values, each under all four combinations of the incoming flags.

// File: rtl/dau_pkg.sv
package dau_pkg;

  typedef enum logic [2:0] {
    DAU_PK_ADD  = 3'd0,
    DAU_PK_SUB  = 3'd1,
    DAU_UP_ADD  = 3'd2,
    DAU_UP_SUB  = 3'd3,
    DAU_SPLIT   = 3'd4,
    DAU_COMBINE = 3'd5,
    DAU_RSV6    = 3'd6,
    DAU_RSV7    = 3'd7
  } dau_op_e;

endpackage

// File: rtl/dau_packed_adj.sv
module dau_packed_adj #(
  parameter int DATA_W   = 8,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic [DATA_W-1:0] val_o,
  output logic              cf_o,
  output logic              af_o
);
  localparam int              NIB_W  = DATA_W / 2;
  localparam logic [DATA_W-1:0] LO_FIX = DATA_W'(6);
  localparam logic [DATA_W-1:0] HI_FIX = LO_FIX << NIB_W;
  localparam logic [DATA_W-1:0] LIMIT  = (DATA_W'(9) << NIB_W) | DATA_W'(9);
  localparam logic [NIB_W-1:0]  NIB_MAX = NIB_W'(9);

  logic              lo_fix;
  logic              hi_fix;
  logic [DATA_W-1:0] stage1;

  // both corrections are decided on the unmodified input byte
  assign lo_fix = (val_i[NIB_W-1:0] > NIB_MAX) | af_i;
  assign hi_fix = (val_i > LIMIT) | cf_i;
  assign af_o   = lo_fix;

  generate
    if (SUBTRACT) begin : g_sub
      always_comb begin
        stage1 = lo_fix ? (val_i - LO_FIX) : val_i;
        val_o  = hi_fix ? (stage1 - HI_FIX) : stage1;
        cf_o   = hi_fix | (lo_fix & (val_i < LO_FIX));
      end
    end else begin : g_add
      always_comb begin
        stage1 = lo_fix ? (val_i + LO_FIX) : val_i;
        val_o  = hi_fix ? (stage1 + HI_FIX) : stage1;
        cf_o   = hi_fix;
      end
    end
  endgenerate

endmodule

// File: rtl/dau_unpacked_adj.sv
module dau_unpacked_adj #(
  parameter int DATA_W   = 8,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic              af_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              cf_o,
  output logic              af_o
);
  localparam int                NIB_W    = DATA_W / 2;
  localparam logic [DATA_W-1:0] LO_FIX   = DATA_W'(6);
  localparam logic [DATA_W-1:0] WRAP_LIM = {DATA_W{1'b1}} - LO_FIX;
  localparam logic [NIB_W-1:0]  NIB_MAX  = NIB_W'(9);

  logic              fix;
  logic              extra;
  logic [DATA_W-1:0] adj;
  logic [DATA_W-1:0] hi_step;

  assign fix = (lo_i[NIB_W-1:0] > NIB_MAX) | af_i;

  generate
    if (SUBTRACT) begin : g_sub
      always_comb begin
        adj     = lo_i - LO_FIX;
        extra   = lo_i < LO_FIX;
        hi_step = hi_i - DATA_W'(1) - DATA_W'(extra);
      end
    end else begin : g_add
      always_comb begin
        adj     = lo_i + LO_FIX;
        extra   = lo_i > WRAP_LIM;
        hi_step = hi_i + DATA_W'(1) + DATA_W'(extra);
      end
    end
  endgenerate

  always_comb begin
    if (fix) begin
      lo_o = {{(DATA_W-NIB_W){1'b0}}, adj[NIB_W-1:0]};
      hi_o = hi_step;
    end else begin
      lo_o = {{(DATA_W-NIB_W){1'b0}}, lo_i[NIB_W-1:0]};
      hi_o = hi_i;
    end
    cf_o = fix;
    af_o = fix;
  end

endmodule

// File: rtl/dau_split_combine.sv
module dau_split_combine #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] base_i,
  output logic [DATA_W-1:0] quo_o,
  output logic [DATA_W-1:0] rem_o,
  output logic [DATA_W-1:0] comb_o
);
  logic [DATA_W:0]   part;
  logic [DATA_W-1:0] rem;
  logic [DATA_W-1:0] quo;

  // restoring division, one quotient bit per unrolled step
  always_comb begin
    rem  = '0;
    quo  = '0;
    part = '0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      part = {rem, lo_i[i]};
      if (part >= {1'b0, base_i}) begin
        part   = part - {1'b0, base_i};
        quo[i] = 1'b1;
      end else begin
        quo[i] = 1'b0;
      end
      rem = part[DATA_W-1:0];
    end
    quo_o = quo;
    rem_o = rem;
  end

  assign comb_o = hi_i * base_i + lo_i;

endmodule

// File: rtl/dau_flag_gen.sv
module dau_flag_gen #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] val_i,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o
);
  assign zf_o = ~|val_i;
  assign sf_o = val_i[DATA_W-1];
  assign pf_o = ~^val_i;
endmodule

// File: rtl/dec_adjust_unit.sv
module dec_adjust_unit #(
  parameter int DATA_W = 8
) (
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic              cf_i,
  input  logic              af_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              cf_o,
  output logic              af_o,
  output logic              zf_o,
  output logic              sf_o,
  output logic              pf_o
);
  import dau_pkg::*;

  localparam int N_VAR = 2;

  dau_op_e op_sel;
  assign op_sel = dau_op_e'(op_i);

  logic [DATA_W-1:0] pk_val [N_VAR];
  logic              pk_cf  [N_VAR];
  logic              pk_af  [N_VAR];
  logic [DATA_W-1:0] up_lo  [N_VAR];
  logic [DATA_W-1:0] up_hi  [N_VAR];
  logic              up_cf  [N_VAR];
  logic              up_af  [N_VAR];

  // index 0 is the add variant, index 1 the subtract variant
  generate
    for (genvar g = 0; g < N_VAR; g++) begin : g_var
      dau_packed_adj #(.DATA_W(DATA_W), .SUBTRACT(g == 1)) u_pk (
        .val_i (lo_i),
        .cf_i  (cf_i),
        .af_i  (af_i),
        .val_o (pk_val[g]),
        .cf_o  (pk_cf[g]),
        .af_o  (pk_af[g])
      );
      dau_unpacked_adj #(.DATA_W(DATA_W), .SUBTRACT(g == 1)) u_up (
        .lo_i (lo_i),
        .hi_i (hi_i),
        .af_i (af_i),
        .lo_o (up_lo[g]),
        .hi_o (up_hi[g]),
        .cf_o (up_cf[g]),
        .af_o (up_af[g])
      );
    end
  endgenerate

  logic [DATA_W-1:0] sc_quo;
  logic [DATA_W-1:0] sc_rem;
  logic [DATA_W-1:0] sc_comb;

  dau_split_combine #(.DATA_W(DATA_W)) u_sc (
    .lo_i   (lo_i),
    .hi_i   (hi_i),
    .base_i (base_i),
    .quo_o  (sc_quo),
    .rem_o  (sc_rem),
    .comb_o (sc_comb)
  );

  always_comb begin
    lo_o = lo_i;
    hi_o = hi_i;
    cf_o = cf_i;
    af_o = af_i;
    case (op_sel)
      DAU_PK_ADD, DAU_PK_SUB: begin
        lo_o = pk_val[op_i[0]];
        cf_o = pk_cf[op_i[0]];
        af_o = pk_af[op_i[0]];
      end
      DAU_UP_ADD, DAU_UP_SUB: begin
        lo_o = up_lo[op_i[0]];
        hi_o = up_hi[op_i[0]];
        cf_o = up_cf[op_i[0]];
        af_o = up_af[op_i[0]];
      end
      DAU_SPLIT: begin
        lo_o = sc_rem;
        hi_o = sc_quo;
      end
      DAU_COMBINE: begin
        lo_o = sc_comb;
        hi_o = '0;
      end
      default: begin
        lo_o = lo_i;
        hi_o = hi_i;
      end
    endcase
  end

  dau_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .val_i (lo_o),
    .zf_o  (zf_o),
    .sf_o  (sf_o),
    .pf_o  (pf_o)
  );

endmodule

// File: rtl/dau_checker.sv
module dau_checker #(
  parameter int DATA_W = 8
) (
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] lo_i,
  input logic [DATA_W-1:0] hi_i,
  input logic [DATA_W-1:0] base_i,
  input logic              cf_i,
  input logic              af_i,
  input logic [DATA_W-1:0] lo_o,
  input logic [DATA_W-1:0] hi_o,
  input logic              cf_o,
  input logic              af_o
);
  localparam int NIB_W = DATA_W / 2;

  logic known;
  assign known = !$isunknown({op_i, lo_i, hi_i, base_i, cf_i, af_i, lo_o, hi_o, cf_o, af_o});

  always_comb begin
    if (known) begin
      if (op_i == 3'd0 || op_i == 3'd1) begin
        // R2
        packed_carry_sticky_chk: assert (!cf_i || cf_o)
          else $error("packed adjust dropped incoming carry");
        // R1
        packed_hi_keep_chk: assert (hi_o == hi_i)
          else $error("packed adjust touched high byte");
      end
      if (op_i == 3'd2 || op_i == 3'd3) begin
        // R8
        unpacked_nibble_chk: assert (lo_o[DATA_W-1:NIB_W] == '0)
          else $error("unpacked adjust left upper nibble set");
        // R6
        unpacked_flag_pair_chk: assert (cf_o == af_o)
          else $error("unpacked adjust flags disagree");
      end
      if (op_i == 3'd4 && base_i != '0) begin
        // R9
        split_rem_chk: assert (lo_o < base_i)
          else $error("split remainder not below base");
      end
      if (op_i == 3'd5) begin
        // R10
        combine_hi_chk: assert (hi_o == '0)
          else $error("combine left high byte nonzero");
      end
      if (op_i == 3'd4 || op_i == 3'd5) begin
        // R11
        pass_flags_chk: assert (cf_o == cf_i && af_o == af_i)
          else $error("split/combine altered carry flags");
      end
    end
  end

endmodule

bind dec_adjust_unit dau_checker #(.DATA_W(DATA_W)) u_chk (
  .op_i   (op_i),
  .lo_i   (lo_i),
  .hi_i   (hi_i),
  .base_i (base_i),
  .cf_i   (cf_i),
  .af_i   (af_i),
  .lo_o   (lo_o),
  .hi_o   (hi_o),
  .cf_o   (cf_o),
  .af_o   (af_o)
);

// File: tb/dec_adjust_unit_bench.sv
module dec_adjust_unit_bench;

  logic       clk;
  logic       rst_n;
  logic [2:0] op;
  logic [7:0] lo_in, hi_in, base_in;
  logic       cf_in, af_in;
  logic [7:0] lo_out, hi_out;
  logic       cf_out, af_out, zf_out, sf_out, pf_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  dec_adjust_unit u_dec_adjust_unit (
    .op_i   (op),
    .lo_i   (lo_in),
    .hi_i   (hi_in),
    .base_i (base_in),
    .cf_i   (cf_in),
    .af_i   (af_in),
    .lo_o   (lo_out),
    .hi_o   (hi_out),
    .cf_o   (cf_out),
    .af_o   (af_out),
    .zf_o   (zf_out),
    .sf_o   (sf_out),
    .pf_o   (pf_out)
  );

  // behavioural reference
  int e_lo, e_hi, e_cf, e_af, e_zf, e_sf, e_pf;
  string e_tag;

  task automatic model(input int o, input int l, input int h, input int b,
                       input int c, input int a);
    int nib_cond;
    int ones;
    nib_cond = ((l % 16) > 9) || (a != 0);
    e_lo = l; e_hi = h; e_cf = c; e_af = a;
    case (o)
      0: begin
        e_tag = "R1/R2";
        e_af = nib_cond;
        if (nib_cond != 0) e_lo = (e_lo + 6) % 256;
        e_cf = (l > 153 || c != 0) ? 1 : 0;
        if (e_cf != 0) e_lo = (e_lo + 96) % 256;
      end
      1: begin
        e_tag = "R3/R4";
        e_af = nib_cond;
        e_cf = 0;
        if (nib_cond != 0) begin
          if (l < 6 || c != 0) e_cf = 1;
          e_lo = (e_lo + 250) % 256;
        end
        if (l > 153 || c != 0) begin
          e_lo = (e_lo + 160) % 256;
          e_cf = 1;
        end
      end
      2, 3: begin
        e_tag = (o == 2) ? "R6/R8" : "R7/R8";
        if (nib_cond != 0) begin
          if (o == 2) begin
            e_lo = (l + 6) % 16;
            e_hi = (h + 1 + ((l > 249) ? 1 : 0)) % 256;
          end else begin
            e_lo = (l + 250) % 16;
            e_hi = (h + 512 - 1 - ((l < 6) ? 1 : 0)) % 256;
          end
          e_cf = 1; e_af = 1;
        end else begin
          e_lo = l % 16;
          e_cf = 0; e_af = 0;
        end
      end
      4: begin
        e_tag = "R9/R11";
        if (b == 0) begin e_hi = 255; e_lo = l; end
        else begin e_hi = l / b; e_lo = l % b; end
      end
      5: begin
        e_tag = "R10/R11";
        e_lo = (h * b + l) % 256;
        e_hi = 0;
      end
      default: e_tag = "R12";
    endcase
    e_zf = (e_lo == 0) ? 1 : 0;
    e_sf = (e_lo >= 128) ? 1 : 0;
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (e_lo >> k) & 1;
    e_pf = (ones % 2 == 0) ? 1 : 0;
  endtask

  task automatic apply(input int o, input int l, input int h, input int b,
                       input int c, input int a);
    @(posedge clk);
    op <= 3'(o); lo_in <= 8'(l); hi_in <= 8'(h); base_in <= 8'(b);
    cf_in <= 1'(c); af_in <= 1'(a);
    @(negedge clk);
    model(o, l, h, b, c, a);
    n_checks++;
    if (lo_out != 8'(e_lo) || hi_out != 8'(e_hi) || cf_out != 1'(e_cf) || af_out != 1'(e_af)) begin
      n_fail++;
      $display("FAIL %s op=%0d lo=%02h hi=%02h base=%02h cf=%0d af=%0d: got lo=%02h hi=%02h cf=%0d af=%0d exp lo=%02h hi=%02h cf=%0d af=%0d",
               e_tag, o, l, h, b, c, a, lo_out, hi_out, cf_out, af_out, e_lo, e_hi, e_cf, e_af);
    end
    n_checks++;
    if (zf_out != 1'(e_zf) || sf_out != 1'(e_sf) || pf_out != 1'(e_pf)) begin
      n_fail++;
      $display("FAIL R5 op=%0d lo=%02h: got zf=%0d sf=%0d pf=%0d exp zf=%0d sf=%0d pf=%0d",
               o, l, zf_out, sf_out, pf_out, e_zf, e_sf, e_pf);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    op = 3'd0; lo_in = 8'h00; hi_in = 8'h00; base_in = 8'h00; cf_in = 1'b0; af_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle state with all inputs zero (R1, R5)
    apply(0, 0, 0, 0, 0, 0);
    // directed corners
    apply(0, 8'h9A, 8'h12, 0, 0, 0);   // R2: judged on original byte
    apply(0, 8'h99, 8'h00, 0, 0, 1);   // R1: af forces +6, no carry
    apply(1, 8'h03, 8'h00, 0, 0, 1);   // R3: below 6 sets carry
    apply(1, 8'h9F, 8'h00, 0, 0, 0);   // R4
    apply(2, 8'hFA, 8'h10, 0, 0, 0);   // R6: extra high increment
    apply(2, 8'hF9, 8'hFF, 0, 0, 1);   // R6: no extra, wrap
    apply(3, 8'h05, 8'h00, 0, 0, 1);   // R7: extra borrow
    apply(3, 8'h06, 8'h20, 0, 0, 1);   // R7
    apply(2, 8'h39, 8'h44, 0, 1, 0);   // R8: no correction, carry cleared
    apply(4, 8'hFF, 8'h00, 10, 1, 0);  // R9 R11
    apply(4, 8'h5A, 8'h33, 0, 0, 1);   // R9: zero base
    apply(5, 8'h09, 8'h07, 10, 0, 1);  // R10 R11
    apply(5, 8'hFF, 8'hFF, 8'hFF, 1, 1); // R10 wrap
    apply(6, 8'hA5, 8'h5A, 8'h11, 1, 0); // R12
    apply(7, 8'h00, 8'hC3, 8'h22, 0, 1); // R12
    // sweep every op over every low byte and flag pair
    for (int o = 0; o < 8; o++)
      for (int l = 0; l < 256; l++)
        for (int f = 0; f < 4; f++)
          apply(o, l, (l * 37 + f * 71 + o) % 256,
                (f == 3) ? 0 : ((l * 13 + f * 29 + 1) % 256), f % 2, f / 2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule